// File: doc/BRIEF.md
# Stereo PDM Capture Front End

This block is the host end of a two-microphone pulse-density-modulated link. Both microphones share one clock wire, which the block drives, and one data wire. One microphone launches a bit after every rising clock edge and the other after every falling edge. The block generates that bit clock from the system clock with a programmable even divider, so the duty cycle is always exactly 50%. Everything is sampled in the system clock domain, at the divider phase that creates each clock edge.

At each falling edge the line still holds the bit launched after the preceding rise, and that bit becomes the left sample. At each rising edge the line holds the bit launched after the preceding fall, and that bit becomes the right sample. Each channel has its own single-cycle valid strobe. Each channel also has an optional inversion, so that rising acoustic pressure maps to a rising density of ones. After the clock is enabled, the block blanks the strobes for a programmable number of bit-clock periods while the microphones settle. A per-channel window counter reports how many ones arrived in each group of delivered samples, for loopback checks.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While `enable` is high, `pdm_clk` starts low and changes level once every `half_div` system cycles, so each high phase and each low phase lasts exactly `half_div` cycles (`half_div` >= 1).
- R2: In the system cycle in which `pdm_clk` goes from 1 to 0 under `enable`, `left_vld` may pulse for one cycle. `left_bit` then holds the value `pdm_dat` had at the clock edge that produced the fall, which is the bit launched after the previous rise.
- R3: In the system cycle in which `pdm_clk` goes from 0 to 1 under `enable`, `right_vld` may pulse for one cycle. `right_bit` then holds the value `pdm_dat` had at the clock edge that produced the rise, which is the bit launched after the previous fall. No strobe occurs in any other cycle.
- R4: Number the edges from 1 after each enable. The left sample at fall k is delivered only when k >= `settle_len`. The right sample at rise k is delivered only when k > `settle_len`.
- R5: When `invert_l` = 1 the delivered left bit is the complement of the line value. `invert_r` does the same for the right bit.
- R6: For each channel, every `win_len` delivered samples (`win_len` >= 1), the ones-valid strobe pulses together with the strobe of the last sample. The count output then gives the number of 1s among those `win_len` delivered bits, taken after inversion. Counting restarts at every enable.
- R7: While `enable` is low, `pdm_clk` is low one cycle later and no strobe is raised. The settling blank and the windows start again on the next enable.
- R8: During reset `pdm_clk` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the bit clock and capture |
| half_div | input | DIV_W | System cycles per bit-clock half period |
| settle_len | input | SETTLE_W | Blanking length in bit-clock periods |
| invert_l | input | 1 | Complement left samples |
| invert_r | input | 1 | Complement right samples |
| win_len | input | WIN_W | Samples per density window |
| pdm_clk | output | 1 | Bit clock to both microphones |
| pdm_dat | input | 1 | Shared data line |
| left_bit | output | 1 | Left sample |
| left_vld | output | 1 | Left sample strobe |
| right_bit | output | 1 | Right sample |
| right_vld | output | 1 | Right sample strobe |
| left_ones | output | WIN_W+1 | Ones in last left window |
| left_ones_vld | output | 1 | Left window complete |
| right_ones | output | WIN_W+1 | Ones in last right window |
| right_ones_vld | output | 1 | Right window complete |

## Verification
The assertions assume that `half_div`, `settle_len`, `win_len` and both inversion controls stay constant while `enable` is high, and that `half_div` and `win_len` are at least 1. The stimulus changes configuration only while the block is disabled and uses only nonzero divider and window values. The modelled microphones change `pdm_dat` half a system cycle after they see a bit-clock edge, so the line is always settled by the sampling edge. This includes the tightest divider, where one half period is a single system cycle.

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx #(
  parameter int DIV_W    = 8,
  parameter int SETTLE_W = 16,
  parameter int WIN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [DIV_W-1:0]    half_div,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                invert_l,
  input  logic                invert_r,
  input  logic [WIN_W-1:0]    win_len,
  output logic                pdm_clk,
  input  logic                pdm_dat,
  output logic                left_bit,
  output logic                left_vld,
  output logic                right_bit,
  output logic                right_vld,
  output logic [WIN_W:0]      left_ones,
  output logic                left_ones_vld,
  output logic [WIN_W:0]      right_ones,
  output logic                right_ones_vld
);

  localparam logic [DIV_W-1:0]    ONE_D = 1;
  localparam logic [SETTLE_W-1:0] ONE_S = 1;
  localparam logic [WIN_W-1:0]    ONE_W = 1;

  logic [DIV_W-1:0]    div_cnt;
  logic                clk_q;
  logic [SETTLE_W-1:0] settle_cnt;

  wire tick    = enable && (div_cnt == half_div - ONE_D);
  wire rise_ev = tick && !clk_q;
  wire fall_ev = tick && clk_q;
  wire settled = (settle_cnt >= settle_len);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      div_cnt    <= '0;
      clk_q      <= 1'b0;
      settle_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      clk_q   <= ~clk_q;
      if (!clk_q && !settled) settle_cnt <= settle_cnt + ONE_S;
    end else begin
      div_cnt <= div_cnt + ONE_D;
    end
  end

  assign pdm_clk = clk_q;

  wire ev  [2];
  wire inv [2];
  assign ev[0]  = fall_ev;
  assign ev[1]  = rise_ev;
  assign inv[0] = invert_l;
  assign inv[1] = invert_r;

  logic           bit_q      [2];
  logic           vld_q      [2];
  logic           ones_vld_q [2];
  logic [WIN_W:0] acc_q      [2];
  logic [WIN_W:0] ones_q     [2];
  logic [WIN_W-1:0] scnt_q   [2];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire smp = pdm_dat ^ inv[c];
    wire [WIN_W:0] acc_nx = acc_q[c] + {{WIN_W{1'b0}}, smp};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bit_q[c]      <= 1'b0;
        vld_q[c]      <= 1'b0;
        ones_vld_q[c] <= 1'b0;
        acc_q[c]      <= '0;
        ones_q[c]     <= '0;
        scnt_q[c]     <= '0;
      end else begin
        vld_q[c]      <= 1'b0;
        ones_vld_q[c] <= 1'b0;
        if (!enable) begin
          acc_q[c]  <= '0;
          scnt_q[c] <= '0;
        end else if (ev[c] && settled) begin
          bit_q[c] <= smp;
          vld_q[c] <= 1'b1;
          if (scnt_q[c] == win_len - ONE_W) begin
            ones_q[c]     <= acc_nx;
            ones_vld_q[c] <= 1'b1;
            acc_q[c]      <= '0;
            scnt_q[c]     <= '0;
          end else begin
            acc_q[c]  <= acc_nx;
            scnt_q[c] <= scnt_q[c] + ONE_W;
          end
        end
      end
    end
  end

  assign left_bit       = bit_q[0];
  assign left_vld       = vld_q[0];
  assign left_ones      = ones_q[0];
  assign left_ones_vld  = ones_vld_q[0];
  assign right_bit      = bit_q[1];
  assign right_vld      = vld_q[1];
  assign right_ones     = ones_q[1];
  assign right_ones_vld = ones_vld_q[1];

  // R7
  off_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pdm_clk);

  // R7
  off_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(left_vld || right_vld));

  // R2
  left_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_vld |-> $fell(pdm_clk));

  // R3
  right_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    right_vld |-> $rose(pdm_clk));

  // R6
  left_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_ones_vld |-> left_vld);

  // R6
  right_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    right_ones_vld |-> right_vld);

endmodule

// File: tb/pdm_stereo_rx_test.sv
module pdm_stereo_rx_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  hd;
    logic [15:0] settle;
    logic        il;
    logic        ir;
    logic [7:0]  win;
    logic [7:0]  lp;
    logic [7:0]  rp;
    logic [15:0] per;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 16'd0, 1'b0, 1'b0, 8'd4, 8'hA5, 8'h3C, 16'd40},
    '{8'd3, 16'd3, 1'b1, 1'b0, 8'd5, 8'hF0, 8'h0F, 16'd40},
    '{8'd1, 16'd1, 1'b0, 1'b1, 8'd8, 8'hFF, 8'h00, 16'd40},
    '{8'd5, 16'd7, 1'b1, 1'b1, 8'd3, 8'h96, 8'h69, 16'd30},
    '{8'd4, 16'd0, 1'b0, 1'b0, 8'd1, 8'h01, 8'hFE, 16'd20},
    '{8'd3, 16'd3, 1'b1, 1'b0, 8'd5, 8'hF0, 8'h0F, 16'd40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic [15:0] settle_len = '0;
  logic invert_l = 1'b0, invert_r = 1'b0;
  logic [7:0] win_len = 8'd1;
  logic pdm_dat = 1'b0;
  logic pdm_clk, left_bit, left_vld, right_bit, right_vld;
  logic [8:0] left_ones, right_ones;
  logic left_ones_vld, right_ones_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_stereo_rx uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .settle_len(settle_len), .invert_l(invert_l), .invert_r(invert_r),
    .win_len(win_len), .pdm_clk(pdm_clk), .pdm_dat(pdm_dat),
    .left_bit(left_bit), .left_vld(left_vld), .right_bit(right_bit),
    .right_vld(right_vld), .left_ones(left_ones), .left_ones_vld(left_ones_vld),
    .right_ones(right_ones), .right_ones_vld(right_ones_vld)
  );

  int tests = 0, fails = 0, cyc = 0;
  int vsel = 0, vseen = -1;
  int nr, nf, run, edges, ldel, rdel, lwin, rwin, lacc, lcnt, racc, rcnt;
  logic prev_pclk = 1'b0;
  logic en_at_edge = 1'b0;
  vec_t cv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    en_at_edge <= enable;
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (vsel != vseen) begin
      vseen = vsel;
      cv = VECS[vsel];
      nr = 0; nf = 0; run = 0; edges = 0;
      ldel = 0; rdel = 0; lwin = 0; rwin = 0;
      lacc = 0; lcnt = 0; racc = 0; rcnt = 0;
      pdm_dat = cv.rp[0];
    end
    if (rst_n) begin
      if (en_at_edge) begin
        run++;
        if (pdm_clk != prev_pclk) begin
          if (edges > 0) chk(run == int'(cv.hd), "R1 half period", run, cv.hd);
          edges++;
          run = 0;
          if (pdm_clk) begin
            nr++;
            chk(right_vld == (nr > int'(cv.settle)), "R4 right blank", right_vld, nr > int'(cv.settle));
            if (right_vld) begin
              rdel++;
              chk(right_bit == (cv.rp[(nr-1)%8] ^ cv.ir), "R3 R5 right bit", right_bit, cv.rp[(nr-1)%8] ^ cv.ir);
              racc += right_bit; rcnt++;
              if (rcnt == int'(cv.win)) begin
                chk(right_ones_vld && right_ones == racc, "R6 right window", right_ones, racc);
                rwin++; racc = 0; rcnt = 0;
              end else if (right_ones_vld) chk(0, "R6 right early window", 1, 0);
            end
            if (left_vld) chk(0, "R2 left on rise", 1, 0);
            pdm_dat = cv.lp[nr%8];
          end else begin
            nf++;
            chk(left_vld == (nf >= int'(cv.settle)), "R4 left blank", left_vld, nf >= int'(cv.settle));
            if (left_vld) begin
              ldel++;
              chk(left_bit == (cv.lp[nf%8] ^ cv.il), "R2 R5 left bit", left_bit, cv.lp[nf%8] ^ cv.il);
              lacc += left_bit; lcnt++;
              if (lcnt == int'(cv.win)) begin
                chk(left_ones_vld && left_ones == lacc, "R6 left window", left_ones, lacc);
                lwin++; lacc = 0; lcnt = 0;
              end else if (left_ones_vld) chk(0, "R6 left early window", 1, 0);
            end
            if (right_vld) chk(0, "R3 right on fall", 1, 0);
            pdm_dat = cv.rp[nf%8];
          end
        end else if (left_vld || right_vld) begin
          chk(0, "R3 strobe without edge", 1, 0);
        end
      end else begin
        if (pdm_clk || left_vld || right_vld)
          chk(0, "R7 activity while disabled", {pdm_clk, left_vld, right_vld}, 0);
      end
    end
    prev_pclk = pdm_clk;
  end

  initial begin
    int guard;
    int lfirst, lexp, rexp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pdm_clk && !left_vld && !right_vld && !left_ones_vld && !right_ones_vld,
        "R8 reset outputs", {pdm_clk, left_vld, right_vld}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!pdm_clk && !left_vld && !right_vld, "R7 idle before enable", pdm_clk, 0);

    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #2;
      vsel = v;
      half_div = VECS[v].hd; settle_len = VECS[v].settle;
      invert_l = VECS[v].il; invert_r = VECS[v].ir; win_len = VECS[v].win;
      @(negedge clk);
      @(posedge clk); #2 enable = 1'b1;
      guard = 0;
      while (nr < int'(VECS[v].per) && guard < 20000) begin
        @(negedge clk); guard++;
      end
      if (guard >= 20000) chk(0, "R1 clock stalled", nr, VECS[v].per);
      @(posedge clk); #2 enable = 1'b0;
      repeat (6) @(negedge clk);
      chk(!pdm_clk, "R7 clock low after disable", pdm_clk, 0);
      lfirst = (int'(VECS[v].settle) > 1) ? int'(VECS[v].settle) : 1;
      lexp = (nf >= lfirst) ? nf - lfirst + 1 : 0;
      rexp = (nr > int'(VECS[v].settle)) ? nr - int'(VECS[v].settle) : 0;
      chk(ldel == lexp, "R4 left delivered count", ldel, lexp);
      chk(rdel == rexp, "R4 right delivered count", rdel, rexp);
      chk(lwin == lexp / int'(VECS[v].win), "R6 left window count", lwin, lexp / int'(VECS[v].win));
      chk(rwin == rexp / int'(VECS[v].win), "R6 right window count", rwin, rexp / int'(VECS[v].win));
    end

    @(posedge clk); #2 rst_n = 1'b0;
    @(negedge clk);
    chk(!pdm_clk && !left_vld && !right_vld, "R8 reset after run", pdm_clk, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule